// File: doc/BRIEF.md
# Video Frame-Store Pixel Datapath

This block carries one 24-bit RGB pixel per dot clock from a video input to a video output. It also drives and reads a 16-bit external frame RAM data bus. A mode input picks one of five operations:

- plain pass-through;
- logo compensation, which applies a per-pixel gain and offset taken from a stored template;
- capture of the live frame into RAM;
- display of the RAM contents;
- a half-and-half crossfade of live and stored video.

During capture the live pixel is packed into a 16-bit word and driven onto the RAM bus. In every other mode the bus is released so that the RAM, or whatever else shares the bus, can drive it.

Every input is registered on entry, the computed pixel is registered in a middle stage, and the RGB output is registered before it leaves. The output therefore trails its inputs by exactly three clocks in every mode. The mode input travels down the pipeline with the pixel it applies to. RAM addressing, colour-space conversion and the spatial filter sit outside this block. A flag for the downstream filter comes out aligned with the pixel.

Top module: `fs_pixel_path`

## Requirements
- R1: Pixel bus `vin_i`/`vout_o` is packed {red[23:16], green[15:8], blue[7:0]}. Mode codes are 0 pass-through, 1 compensation, 2 capture, 3 display and 4 crossfade; codes 5 to 7 behave as pass-through. In pass-through, `vout_o` equals the `vin_i` that was presented three rising edges earlier.
- R2: In capture mode, `ram_dq` drives {R[7:3], G[7:2], B[7:3]} of the live pixel two rising edges after that pixel is presented, and `vout_o` shows the live pixel unchanged with the three-clock latency.
- R3: In every mode other than capture, `ram_dq` is high impedance, two rising edges after the mode is presented.
- R4: In display mode, the word read from `ram_dq` alongside the pixel is expanded to RGB with the same latency as R1. The 5-bit red and blue fields and the 6-bit green field each get their top bits repeated below them: R = {w[15:11], w[15:13]}, G = {w[10:5], w[10:9]}, B = {w[4:0], w[4:2]}.
- R5: In crossfade mode each output channel is floor((live + stored)/2), where stored is the expansion of R4.
- R6: In compensation mode each channel is floor(in*m/128) - c, computed without truncation. With m = 128 and c = 0 the pixel passes unchanged.
- R7: Compensation results above 255 are limited to 255 and never wrap.
- R8: Compensation results below 0 are limited to 0 and never wrap.
- R9: `filt_en_o` is 1 exactly when the `tmpl_m_i` presented with the pixel is greater than 128, aligned with that pixel's output. This holds in every mode.
- R10: While reset is asserted, `vout_o` is 0, `filt_en_o` is 0 and `ram_dq` is high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Operating mode code |
| vin_i | input | 24 | Live RGB pixel |
| tmpl_m_i | input | 8 | Template gain, 128 = unity |
| tmpl_c_i | input | 8 | Template darkening offset |
| ram_dq | inout | 16 | Frame RAM data bus, driven only in capture mode |
| vout_o | output | 24 | Output RGB pixel |
| filt_en_o | output | 1 | Downstream filter enable, aligned with `vout_o` |

## Verification
The assertions check four behaviours on every cycle against the inputs seen a fixed number of clocks earlier: pass-through fidelity, the capture word on the bus, bus release outside capture, and the filter flag. They also check that unity gain with zero offset is an exact identity. The clamping at both ends, the field expansion of stored words and the crossfade rounding are shown only by the bench's directed scenarios. The bench uses operand values chosen to sit at and beyond the limits. It holds each stimulus for exactly three edges, so an output delayed by even one extra register would show the previous value.

// File: rtl/fs_pkg.sv
package fs_pkg;
    localparam int CW = 8;
    localparam int WW = 16;
    localparam int MW = 3;
    localparam int RBITS = 5;
    localparam int GBITS = 6;
    localparam int UNITY_SHIFT = 7;

    localparam logic [MW-1:0] MD_PASS  = 3'd0;
    localparam logic [MW-1:0] MD_COMP  = 3'd1;
    localparam logic [MW-1:0] MD_CAPT  = 3'd2;
    localparam logic [MW-1:0] MD_SHOW  = 3'd3;
    localparam logic [MW-1:0] MD_BLEND = 3'd4;

    typedef struct packed {
        logic [CW-1:0] r;
        logic [CW-1:0] g;
        logic [CW-1:0] b;
    } rgb_t;
endpackage

// File: rtl/fs_comp_chan.sv
module fs_comp_chan #(
    parameter int CW = 8,
    parameter int SH = 7
) (
    input  logic [CW-1:0] pix_i,
    input  logic [CW-1:0] gain_i,
    input  logic [CW-1:0] ofs_i,
    output logic [CW-1:0] y_o
);
    localparam int PW = 2 * CW;
    localparam int QW = PW - SH;
    localparam int DW = QW + 2;
    localparam logic [CW-1:0] YMAX = {CW{1'b1}};

    logic [PW-1:0]        prod;
    logic [QW-1:0]        scaled;
    logic signed [DW-1:0] diff;

    always_comb begin
        prod   = PW'(pix_i) * PW'(gain_i);
        scaled = prod[PW-1:SH];
        diff   = $signed({2'b00, scaled}) - $signed({{(DW-CW){1'b0}}, ofs_i});
        if (diff < 0)
            y_o = '0;
        else if (diff > $signed({{(DW-CW){1'b0}}, YMAX}))
            y_o = YMAX;
        else
            y_o = diff[CW-1:0];
    end
endmodule

// File: rtl/fs_unpack565.sv
module fs_unpack565
    import fs_pkg::*;
(
    input  logic [WW-1:0] word_i,
    output rgb_t          pix_o
);
    localparam int GLO = RBITS;
    localparam int RLO = RBITS + GBITS;

    logic [RBITS-1:0] rf;
    logic [GBITS-1:0] gf;
    logic [RBITS-1:0] bf;

    always_comb begin
        rf = word_i[WW-1:RLO];
        gf = word_i[RLO-1:GLO];
        bf = word_i[RBITS-1:0];
        pix_o.r = {rf, rf[RBITS-1 -: (CW-RBITS)]};
        pix_o.g = {gf, gf[GBITS-1 -: (CW-GBITS)]};
        pix_o.b = {bf, bf[RBITS-1 -: (CW-RBITS)]};
    end
endmodule

// File: rtl/fs_pack565.sv
module fs_pack565
    import fs_pkg::*;
(
    input  rgb_t          pix_i,
    output logic [WW-1:0] word_o
);
    always_comb begin
        word_o = {pix_i.r[CW-1 -: RBITS], pix_i.g[CW-1 -: GBITS], pix_i.b[CW-1 -: RBITS]};
    end
endmodule

// File: rtl/fs_pixel_path.sv
module fs_pixel_path
    import fs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MW-1:0]    mode_i,
    input  logic [3*CW-1:0]  vin_i,
    input  logic [CW-1:0]    tmpl_m_i,
    input  logic [CW-1:0]    tmpl_c_i,
    inout  wire  [WW-1:0]    ram_dq,
    output logic [3*CW-1:0]  vout_o,
    output logic             filt_en_o
);
    localparam logic [CW-1:0] UNITY = CW'(1) << UNITY_SHIFT;
    localparam int NCH = 3;

    typedef struct packed {
        logic [MW-1:0] md1;
        rgb_t          pix1;
        logic [CW-1:0] m1;
        logic [CW-1:0] c1;
        logic [WW-1:0] w1;
        rgb_t          pix2;
        logic          filt2;
        logic [WW-1:0] wo2;
        logic          oe2;
        rgb_t          pix3;
        logic          filt3;
        logic [1:0]    warm;
    } state_t;

    state_t st_d, st_q;

    rgb_t          stored_pix;
    rgb_t          comp_pix;
    rgb_t          blend_pix;
    logic [WW-1:0] packed_w;
    logic [CW-1:0] comp_ch  [NCH];
    logic [CW-1:0] live_ch  [NCH];
    logic [CW-1:0] store_ch [NCH];
    logic [CW-1:0] blend_ch [NCH];

    fs_unpack565 u_unpack (
        .word_i (st_q.w1),
        .pix_o  (stored_pix)
    );

    fs_pack565 u_pack (
        .pix_i  (st_q.pix1),
        .word_o (packed_w)
    );

    assign live_ch[0]  = st_q.pix1.r;
    assign live_ch[1]  = st_q.pix1.g;
    assign live_ch[2]  = st_q.pix1.b;
    assign store_ch[0] = stored_pix.r;
    assign store_ch[1] = stored_pix.g;
    assign store_ch[2] = stored_pix.b;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic [CW:0] sum;
        fs_comp_chan #(.CW(CW), .SH(UNITY_SHIFT)) u_comp (
            .pix_i  (live_ch[ch]),
            .gain_i (st_q.m1),
            .ofs_i  (st_q.c1),
            .y_o    (comp_ch[ch])
        );
        assign sum          = {1'b0, live_ch[ch]} + {1'b0, store_ch[ch]};
        assign blend_ch[ch] = sum[CW:1];
    end

    assign comp_pix  = '{r: comp_ch[0],  g: comp_ch[1],  b: comp_ch[2]};
    assign blend_pix = '{r: blend_ch[0], g: blend_ch[1], b: blend_ch[2]};

    always_comb begin
        st_d = st_q;
        // stage 1: register everything on entry
        st_d.md1  = mode_i;
        st_d.pix1 = rgb_t'(vin_i);
        st_d.m1   = tmpl_m_i;
        st_d.c1   = tmpl_c_i;
        st_d.w1   = ram_dq;
        // stage 2: mode-selected result and bus drive
        case (st_q.md1)
            MD_COMP:  st_d.pix2 = comp_pix;
            MD_SHOW:  st_d.pix2 = stored_pix;
            MD_BLEND: st_d.pix2 = blend_pix;
            default:  st_d.pix2 = st_q.pix1;
        endcase
        st_d.filt2 = st_q.m1 > UNITY;
        st_d.oe2   = st_q.md1 == MD_CAPT;
        st_d.wo2   = packed_w;
        // stage 3: output register
        st_d.pix3  = st_q.pix2;
        st_d.filt3 = st_q.filt2;
        st_d.warm  = (st_q.warm == 2'd3) ? st_q.warm : st_q.warm + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign ram_dq    = st_q.oe2 ? st_q.wo2 : {WW{1'bz}};
    assign vout_o    = st_q.pix3;
    assign filt_en_o = st_q.filt3;

    p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.warm == 2'd3 && $past(mode_i, 3) == MD_PASS) |-> vout_o == $past(vin_i, 3));

    p_capt_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.warm >= 2'd2 && $past(mode_i, 2) == MD_CAPT) |->
        (st_q.oe2 && st_q.wo2 == {$past(vin_i[23:19], 2), $past(vin_i[15:10], 2), $past(vin_i[7:3], 2)}));

    p_bus_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.warm >= 2'd2 && $past(mode_i, 2) != MD_CAPT) |-> !st_q.oe2);

    p_unity_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.warm == 2'd3 && $past(mode_i, 3) == MD_COMP && $past(tmpl_m_i, 3) == UNITY
         && $past(tmpl_c_i, 3) == '0) |-> vout_o == $past(vin_i, 3));

    p_filt_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.warm == 2'd3) |-> filt_en_o == ($past(tmpl_m_i, 3) > UNITY));
endmodule

// File: tb/fs_pixel_path_bench.sv
module fs_pixel_path_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode;
    logic [23:0] vin;
    logic [7:0]  m, c;
    logic [15:0] tb_word;
    logic        tb_drv;
    wire  [15:0] ram_dq;
    logic [23:0] vout;
    logic        filt;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    assign ram_dq = tb_drv ? tb_word : 16'bz;

    fs_pixel_path u_fs_pixel_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode),
        .vin_i     (vin),
        .tmpl_m_i  (m),
        .tmpl_c_i  (c),
        .ram_dq    (ram_dq),
        .vout_o    (vout),
        .filt_en_o (filt)
    );

    function automatic logic [7:0] e_comp(logic [7:0] x, logic [7:0] g, logic [7:0] o);
        int v;
        v = (int'(x) * int'(g)) / 128 - int'(o);
        if (v < 0) v = 0;
        if (v > 255) v = 255;
        return 8'(v);
    endfunction

    function automatic logic [23:0] e_expand(logic [15:0] w);
        return {w[15:11], w[15:13], w[10:5], w[10:9], w[4:0], w[4:2]};
    endfunction

    function automatic logic [23:0] e_blend(logic [23:0] a, logic [23:0] b);
        logic [23:0] r;
        for (int i = 0; i < 3; i++)
            r[i*8 +: 8] = 8'((int'(a[i*8 +: 8]) + int'(b[i*8 +: 8])) / 2);
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step(logic [2:0] md, logic [23:0] px, logic [7:0] gm,
                        logic [7:0] gc, logic [15:0] w, logic drv);
        @(negedge clk);
        mode = md; vin = px; m = gm; c = gc; tb_word = w; tb_drv = drv;
        repeat (3) @(posedge clk);
        #2;
    endtask

    task automatic t_reset;
        chk("R10 vout", {8'h0, vout}, 32'h0);
        chk("R10 filt", {31'h0, filt}, 32'h0);
        chk("R10 bus", {16'h0, ram_dq}, {16'h0, 16'hzzzz});
    endtask

    task automatic t_pass;
        step(3'd0, 24'h12A5F0, 8'd200, 8'd9, 16'h0, 1'b0);
        chk("R1 pass a", {8'h0, vout}, {8'h0, 24'h12A5F0});
        step(3'd0, 24'hFF0180, 8'd0, 8'd0, 16'h0, 1'b0);
        chk("R1 pass b", {8'h0, vout}, {8'h0, 24'hFF0180});
        step(3'd6, 24'h3C7E01, 8'd0, 8'd0, 16'hFFFF, 1'b1);
        chk("R1 code6 pass", {8'h0, vout}, {8'h0, 24'h3C7E01});
    endtask

    task automatic t_capture;
        step(3'd2, 24'hF8FC08, 8'd0, 8'd0, 16'h0, 1'b0);
        chk("R2 word a", {16'h0, ram_dq}, {16'h0, 16'hFFE1});
        chk("R2 live out", {8'h0, vout}, {8'h0, 24'hF8FC08});
        step(3'd2, 24'h8A4C17, 8'd0, 8'd0, 16'h0, 1'b0);
        chk("R2 word b", {16'h0, ram_dq}, {16'h0, {5'h11, 6'h13, 5'h02}});
    endtask

    task automatic t_release;
        step(3'd1, 24'h808080, 8'd128, 8'd0, 16'h0, 1'b0);
        chk("R3 comp bus z", {16'h0, ram_dq}, {16'h0, 16'hzzzz});
        step(3'd0, 24'h808080, 8'd128, 8'd0, 16'h0, 1'b0);
        chk("R3 pass bus z", {16'h0, ram_dq}, {16'h0, 16'hzzzz});
    endtask

    task automatic t_show;
        step(3'd3, 24'h000000, 8'd0, 8'd0, 16'hF81F, 1'b1);
        chk("R4 show a", {8'h0, vout}, {8'h0, e_expand(16'hF81F)});
        step(3'd3, 24'hFFFFFF, 8'd0, 8'd0, 16'h8A52, 1'b1);
        chk("R4 show b", {8'h0, vout}, {8'h0, e_expand(16'h8A52)});
    endtask

    task automatic t_blend;
        step(3'd4, 24'h10FF03, 8'd0, 8'd0, 16'hFFFF, 1'b1);
        chk("R5 blend a", {8'h0, vout}, {8'h0, e_blend(24'h10FF03, 24'hFFFFFF)});
        step(3'd4, 24'h7F0001, 8'd0, 8'd0, 16'h4208, 1'b1);
        chk("R5 blend b", {8'h0, vout}, {8'h0, e_blend(24'h7F0001, e_expand(16'h4208))});
    endtask

    task automatic t_comp;
        logic [23:0] px;
        px = 24'hC86411;
        step(3'd1, px, 8'd128, 8'd0, 16'h0, 1'b0);
        chk("R6 unity", {8'h0, vout}, {8'h0, px});
        chk("R9 m128 off", {31'h0, filt}, 32'h0);
        step(3'd1, px, 8'd64, 8'd5, 16'h0, 1'b0);
        chk("R6 half minus c", {8'h0, vout},
            {8'h0, e_comp(px[23:16], 8'd64, 8'd5), e_comp(px[15:8], 8'd64, 8'd5), e_comp(px[7:0], 8'd64, 8'd5)});
        step(3'd1, 24'hFFC010, 8'd255, 8'd0, 16'h0, 1'b0);
        chk("R7 clamp high", {8'h0, vout},
            {8'h0, 8'hFF, 8'hFF, e_comp(8'h10, 8'd255, 8'd0)});
        chk("R9 m255 on", {31'h0, filt}, 32'h1);
        step(3'd1, 24'h0A3002, 8'd129, 8'd40, 16'h0, 1'b0);
        chk("R8 clamp low", {8'h0, vout},
            {8'h0, e_comp(8'h0A, 8'd129, 8'd40), e_comp(8'h30, 8'd129, 8'd40), 8'h00});
        chk("R9 m129 on", {31'h0, filt}, 32'h1);
        step(3'd0, 24'h0, 8'd129, 8'd0, 16'h0, 1'b0);
        chk("R9 any mode", {31'h0, filt}, 32'h1);
    endtask

    initial begin
        mode = 3'd0; vin = '0; m = '0; c = '0; tb_word = '0; tb_drv = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        t_reset;
        @(negedge clk);
        rst_n = 1'b1;
        t_pass;
        t_capture;
        t_release;
        t_show;
        t_blend;
        t_comp;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule